// File: doc/BRIEF.md
# Seven-Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction word into the control lines of a single-cycle datapath. It recognises seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch on equal and unconditional jump. The opcode sits in bits 31:26 of the word. For register-format instructions the function code sits in bits 5:0. The surrounding datapath slices both fields out and presents them here. The block is purely combinational, so every output settles in the same cycle as its inputs.

The logic has two layers. The first is a row of AND terms, one for each instruction, and at most one of them is true. The second is a set of OR terms, one for each control line, that collects the instructions needing that line. Any encoding outside the seven recognised ones raises an illegal-instruction flag, and every control line is then held low, so no register, memory or program-counter update can take place. Outputs that would otherwise be don't-care are also driven low, which makes every output a fixed function of the inputs. Both fields are plain control pins, with no handshake.

Top module: `ctl_decoder`

## Requirements
- R1: The codes are recognised as follows: add is opcode 000000 with function 100000, sub is opcode 000000 with function 100010, ori is 001101, lw is 100011, sw is 101011, beq is 000100 and j is 000010. For any non-zero opcode the function field has no effect on any output.
- R2: `dst_rd_o` is 1 exactly for add and sub.
- R3: `alu_b_imm_o` is 1 exactly for ori, lw and sw.
- R4: `wb_mem_o` is 1 exactly for lw.
- R5: `rf_we_o` is 1 exactly for add, sub, ori and lw.
- R6: `dm_we_o` is 1 exactly for sw.
- R7: `br_sel_o` is 1 exactly for beq, and `jmp_sel_o` is 1 exactly for j.
- R8: `imm_sign_o` is 1 (sign extension) for lw and sw. It is 0 (zero extension) for ori and for every other encoding.
- R9: `alu_op_o` is 2'b00 (add) for add, lw, sw and j, 2'b01 (subtract) for sub and beq, and 2'b10 (OR) for ori. It is 2'b00 for illegal encodings.
- R10: `illegal_o` is 1 for every encoding not listed in R1. Whenever it is 1, every other output is 0.
- R11: At most one of `rf_we_o`, `dm_we_o`, `br_sel_o` and `jmp_sel_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field, instruction bits 31:26 |
| fn_i | input | 6 | Function field, instruction bits 5:0 |
| dst_rd_o | output | 1 | Write-back register comes from the rd field (0: from rt) |
| alu_b_imm_o | output | 1 | ALU second operand is the extended immediate (0: register) |
| wb_mem_o | output | 1 | Write-back data comes from data memory (0: from the ALU) |
| rf_we_o | output | 1 | Register file write enable |
| dm_we_o | output | 1 | Data memory write enable |
| br_sel_o | output | 1 | Next-PC selects the equal-branch target |
| jmp_sel_o | output | 1 | Next-PC selects the jump target |
| imm_sign_o | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |
| illegal_o | output | 1 | Encoding is not one of the seven recognised instructions |

## Verification
The assertions assume that both input fields carry known 0/1 values. With an X or Z input, the one-hot and exclusion checks on the outputs would not mean anything. The stimulus therefore drives only fully defined codes. It sweeps all 64 function values under opcode 000000, and for every other opcode it applies a fixed set of function values to show that the field has no effect. Each code is held for a whole clock period, so the combinational outputs have settled before they are sampled.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  // recognised instruction kinds, index into the AND-term vector
  localparam int K_ADD  = 0;
  localparam int K_SUB  = 1;
  localparam int K_ORI  = 2;
  localparam int K_LW   = 3;
  localparam int K_SW   = 4;
  localparam int K_BEQ  = 5;
  localparam int K_J    = 6;
  localparam int N_KIND = 7;

  // control lines, index into the OR-term vector
  localparam int L_DST   = 0;
  localparam int L_BIMM  = 1;
  localparam int L_WBMEM = 2;
  localparam int L_RFWE  = 3;
  localparam int L_DMWE  = 4;
  localparam int L_BR    = 5;
  localparam int L_JMP   = 6;
  localparam int L_SGN   = 7;
  localparam int L_ALU0  = 8;
  localparam int L_ALU1  = 9;
  localparam int N_LINE  = 10;

  localparam int ALU_W = 2;

  typedef logic [N_KIND-1:0] kind_vec_t;
  typedef logic [N_LINE-1:0] line_vec_t;

  // opcode that selects each kind
  function automatic logic [OP_W-1:0] kind_op(input int k);
    case (k)
      K_ADD, K_SUB: kind_op = 6'b000000;
      K_ORI:        kind_op = 6'b001101;
      K_LW:         kind_op = 6'b100011;
      K_SW:         kind_op = 6'b101011;
      K_BEQ:        kind_op = 6'b000100;
      K_J:          kind_op = 6'b000010;
      default:      kind_op = 6'b111111;
    endcase
  endfunction

  // function code for register-format kinds
  function automatic logic [FN_W-1:0] kind_fn(input int k);
    case (k)
      K_ADD:   kind_fn = 6'b100000;
      K_SUB:   kind_fn = 6'b100010;
      default: kind_fn = 6'b000000;
    endcase
  endfunction

  function automatic logic kind_uses_fn(input int k);
    kind_uses_fn = (k == K_ADD) || (k == K_SUB);
  endfunction

  // which kinds drive each control line (OR-term membership)
  function automatic kind_vec_t line_mask(input int l);
    kind_vec_t m;
    m = '0;
    case (l)
      L_DST:   begin m[K_ADD] = 1'b1; m[K_SUB] = 1'b1; end
      L_BIMM:  begin m[K_ORI] = 1'b1; m[K_LW] = 1'b1; m[K_SW] = 1'b1; end
      L_WBMEM: m[K_LW] = 1'b1;
      L_RFWE:  begin m[K_ADD] = 1'b1; m[K_SUB] = 1'b1; m[K_ORI] = 1'b1; m[K_LW] = 1'b1; end
      L_DMWE:  m[K_SW] = 1'b1;
      L_BR:    m[K_BEQ] = 1'b1;
      L_JMP:   m[K_J] = 1'b1;
      L_SGN:   begin m[K_LW] = 1'b1; m[K_SW] = 1'b1; end
      L_ALU0:  begin m[K_SUB] = 1'b1; m[K_BEQ] = 1'b1; end
      L_ALU1:  m[K_ORI] = 1'b1;
      default: m = '0;
    endcase
    line_mask = m;
  endfunction

endpackage

// File: rtl/ctl_match.sv
module ctl_match
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W,
  parameter int NK  = N_KIND
) (
  input  logic [OPW-1:0] op_i,
  input  logic [FNW-1:0] fn_i,
  output logic [NK-1:0]  hit_o,
  output logic           none_o
);

  for (genvar k = 0; k < NK; k++) begin : g_term
    localparam logic [OPW-1:0] OPC = OPW'(kind_op(k));
    localparam logic [FNW-1:0] FNC = FNW'(kind_fn(k));
    localparam bit             UFN = kind_uses_fn(k);
    if (UFN) begin : g_rfmt
      assign hit_o[k] = (op_i == OPC) && (fn_i == FNC);
    end else begin : g_other
      assign hit_o[k] = (op_i == OPC);
    end
  end

  assign none_o = ~|hit_o;

endmodule

// File: rtl/ctl_combine.sv
module ctl_combine
  import ctl_pkg::*;
#(
  parameter int NK = N_KIND,
  parameter int NL = N_LINE
) (
  input  logic [NK-1:0] hit_i,
  output logic [NL-1:0] line_o
);

  for (genvar l = 0; l < NL; l++) begin : g_line
    localparam logic [NK-1:0] MASK = NK'(line_mask(l));
    assign line_o[l] = |(hit_i & MASK);
  end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             dst_rd_o,
  output logic             alu_b_imm_o,
  output logic             wb_mem_o,
  output logic             rf_we_o,
  output logic             dm_we_o,
  output logic             br_sel_o,
  output logic             jmp_sel_o,
  output logic             imm_sign_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             illegal_o
);

  kind_vec_t hit;
  line_vec_t line;
  logic      none;

  ctl_match #(.OPW(OP_W), .FNW(FN_W), .NK(N_KIND)) u_match (
    .op_i   (op_i),
    .fn_i   (fn_i),
    .hit_o  (hit),
    .none_o (none)
  );

  ctl_combine #(.NK(N_KIND), .NL(N_LINE)) u_combine (
    .hit_i  (hit),
    .line_o (line)
  );

  assign dst_rd_o    = line[L_DST];
  assign alu_b_imm_o = line[L_BIMM];
  assign wb_mem_o    = line[L_WBMEM];
  assign rf_we_o     = line[L_RFWE];
  assign dm_we_o     = line[L_DMWE];
  assign br_sel_o    = line[L_BR];
  assign jmp_sel_o   = line[L_JMP];
  assign imm_sign_o  = line[L_SGN];
  assign alu_op_o    = {line[L_ALU1], line[L_ALU0]};
  assign illegal_o   = none;

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
  import ctl_pkg::*;
(
  input logic [OP_W-1:0]  op_i,
  input logic             dst_rd_o,
  input logic             alu_b_imm_o,
  input logic             wb_mem_o,
  input logic             rf_we_o,
  input logic             dm_we_o,
  input logic             br_sel_o,
  input logic             jmp_sel_o,
  input logic             imm_sign_o,
  input logic [ALU_W-1:0] alu_op_o,
  input logic             illegal_o
);

  always_comb begin
    // R11
    one_effect_chk: assert ($onehot0({rf_we_o, dm_we_o, br_sel_o, jmp_sel_o}));
    // R10
    illegal_quiet_chk: assert (!illegal_o || ({dst_rd_o, alu_b_imm_o, wb_mem_o, rf_we_o,
      dm_we_o, br_sel_o, jmp_sel_o, imm_sign_o, alu_op_o} == '0));
    // R6
    store_op_chk: assert (!dm_we_o || op_i == 6'b101011);
    // R4
    load_path_chk: assert (!wb_mem_o || (rf_we_o && alu_b_imm_o && !dst_rd_o));
    // R2
    rd_rfmt_chk: assert (!dst_rd_o || (op_i == 6'b000000 && rf_we_o));
    // R8
    sign_imm_chk: assert (!imm_sign_o || alu_b_imm_o);
    // R9
    alu_code_chk: assert (alu_op_o != 2'b11);
    // R7
    jump_op_chk: assert (!jmp_sel_o || op_i == 6'b000010);
  end

endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .op_i        (op_i),
  .dst_rd_o    (dst_rd_o),
  .alu_b_imm_o (alu_b_imm_o),
  .wb_mem_o    (wb_mem_o),
  .rf_we_o     (rf_we_o),
  .dm_we_o     (dm_we_o),
  .br_sel_o    (br_sel_o),
  .jmp_sel_o   (jmp_sel_o),
  .imm_sign_o  (imm_sign_o),
  .alu_op_o    (alu_op_o),
  .illegal_o   (illegal_o)
);

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] op, fn;
  logic dst, bimm, wbm, rfwe, dmwe, br, jmp, sgn, ill;
  logic [1:0] alu;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ctl_decoder u_dut (
    .op_i(op), .fn_i(fn),
    .dst_rd_o(dst), .alu_b_imm_o(bimm), .wb_mem_o(wbm), .rf_we_o(rfwe),
    .dm_we_o(dmwe), .br_sel_o(br), .jmp_sel_o(jmp), .imm_sign_o(sgn),
    .alu_op_o(alu), .illegal_o(ill)
  );

  // expected {dst,bimm,wbm,rfwe,dmwe,br,jmp,sgn,alu[1:0],ill} from the requirement table
  function automatic logic [10:0] ref_ctl(input logic [5:0] o, input logic [5:0] f);
    if (o == 6'd0 && f == 6'd32) ref_ctl = 11'b1_0_0_1_0_0_0_0_00_0;      // add
    else if (o == 6'd0 && f == 6'd34) ref_ctl = 11'b1_0_0_1_0_0_0_0_01_0; // sub
    else if (o == 6'd13) ref_ctl = 11'b0_1_0_1_0_0_0_0_10_0;              // ori
    else if (o == 6'd35) ref_ctl = 11'b0_1_1_1_0_0_0_1_00_0;              // lw
    else if (o == 6'd43) ref_ctl = 11'b0_1_0_0_1_0_0_1_00_0;              // sw
    else if (o == 6'd4)  ref_ctl = 11'b0_0_0_0_0_1_0_0_01_0;              // beq
    else if (o == 6'd2)  ref_ctl = 11'b0_0_0_0_0_0_1_0_00_0;              // j
    else ref_ctl = 11'b0_0_0_0_0_0_0_0_00_1;
  endfunction

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b fn=%b got=%b exp=%b", tag, op, fn, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [5:0] f);
    logic [10:0] e;
    @(posedge clk);
    op = o;
    fn = f;
    @(negedge clk);
    e = ref_ctl(o, f);
    chk("R1",  {1'b0, ~ill}, {1'b0, ~e[0]});
    chk("R2",  {1'b0, dst},  {1'b0, e[10]});
    chk("R3",  {1'b0, bimm}, {1'b0, e[9]});
    chk("R4",  {1'b0, wbm},  {1'b0, e[8]});
    chk("R5",  {1'b0, rfwe}, {1'b0, e[7]});
    chk("R6",  {1'b0, dmwe}, {1'b0, e[6]});
    chk("R7",  {br, jmp},    e[5:4]);
    chk("R8",  {1'b0, sgn},  {1'b0, e[3]});
    chk("R9",  alu,          e[2:1]);
    chk("R10", {1'b0, ill},  {1'b0, e[0]});
    chk("R11", {1'b0, 1'($countones({rfwe, dmwe, br, jmp}) > 1)}, 2'b00);
  endtask

  initial begin
    op = '0;
    fn = '0;
    // initial state: all-zero word is an illegal register-format code
    @(negedge clk);
    chk("R10", {1'b0, ill}, 2'b01);
    chk("R5", {1'b0, rfwe}, 2'b00);
    // every function code under the register-format opcode
    for (int f = 0; f < 64; f++) apply(6'd0, 6'(f));
    // every other opcode with assorted function codes (R1: no effect)
    for (int o = 1; o < 64; o++) begin
      apply(6'(o), 6'd0);
      apply(6'(o), 6'd32);
      apply(6'(o), 6'd34);
      apply(6'(o), 6'd63);
      apply(6'(o), 6'(o));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule